// File: doc/BRIEF.md
# Serial Port Idle Wakeup Controller

This block sits beside a buffered serial port and handles its side of the idle handshake with an external power manager. When the manager raises an idle request, the block answers with an idle acknowledge. The mode input selects how it answers. In forced mode the acknowledge comes at once and the block signals that its clocks may be frozen. In cooperative (smart) mode the acknowledge waits until no enabled interrupt is pending. While the port is idle in smart mode, it watches the events that the receive and transmit paths report. When one of them is enabled as a wakeup source, it raises a wakeup request.

The path events are:
- a rising receive-buffer fill level;
- a rising transmit-buffer free-space level;
- end-of-frame strobes;
- a transmit frame-sync pulse;
- frame-sync error strobes.

Each event sets a sticky status bit, whether or not it is a wakeup source. The single interrupt line is the OR of the status bits that software has enabled. It is held low while the port is idle, so a wakeup cause is reported once the port is active again. Software reaches the configuration and status through a small write-strobe and combinational-read register interface.

Top module: `sport_idle_wake`

## Requirements
- R1: After reset, idle_ack, wakeup, clk_freeze and irq are 0, and every register reads back as 0.
- R2: With smart_mode=0, an idle request seen in the active state gives idle_ack=1 and clk_freeze=1 on the next clock, even when an enabled interrupt is pending.
- R3: While clk_freeze=1, no path event sets a status bit and wakeup stays 0.
- R4: With smart_mode=1, idle_ack rises only on the clock after a cycle in which idle_req=1 and no status bit is both set and interrupt-enabled.
- R5: Status bit 0 sets when rx_level moves from below thr_rx+1 to at least thr_rx+1. A level that stays at or above the limit sets it only once.
- R6: Status bit 3 sets when tx_space moves from below thr_tx+1 to at least thr_tx+1.
- R7: Each strobe sets its own status bit: rx_eof sets bit 1, rx_sync_err sets bit 2, tx_eof sets bit 4 and tx_sync_err sets bit 6.
- R8: A tx_fsync pulse sets status bit 5 only while idle_ack=1. In the active state it has no effect.
- R9: In smart idle, an event whose bit is set in the wake-enable register raises wakeup on the next clock. wakeup then holds while idle_req=1. One clock after idle_req falls, idle_ack and wakeup are both 0.
- R10: In smart idle, an event whose wake-enable bit is clear sets its status bit but does not raise wakeup.
- R11: irq equals the OR of (status AND irq-enable) while idle_ack=0, and it is 0 while idle_ack=1.
- R12: A write to the status address clears the bits written as 1 and keeps the bits written as 0. An event in the same cycle as a clear of its bit leaves the bit set.
- R13: The registers are at these addresses, and each reads back what was written:
  - address 0: wake-enable;
  - address 1: irq-enable;
  - address 2: thr_rx;
  - address 3: thr_tx;
  - address 4: status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Idle request from the power manager |
| smart_mode | input | 1 | 1 = smart idle, 0 = forced idle |
| rx_level | input | LVL_W | Receive buffer fill level |
| tx_space | input | LVL_W | Transmit buffer free space |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_sync_err | input | 1 | Unexpected receive frame-sync strobe |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_fsync | input | 1 | Transmit frame-sync pulse |
| tx_sync_err | input | 1 | Unexpected transmit frame-sync strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data, combinational from reg_addr |
| idle_ack | output | 1 | Idle acknowledge |
| wakeup | output | 1 | Wakeup request |
| clk_freeze | output | 1 | Clocks may be stopped (forced idle) |
| irq | output | 1 | Combined interrupt |

## Verification
Every result of this block is due exactly one clock after the stimulus that causes it. This covers the following:
- an event sets its status bit;
- an idle request changes idle_ack and clk_freeze;
- a wake-enabled event raises wakeup;
- the fall of idle_req releases the handshake;
- a register write takes effect.

The irq output and reg_rdata follow the registered state within the same cycle. The bench changes inputs just after a falling edge. It crosses one rising edge and samples at the next falling edge, so every check reads the value that the single register stage has produced. A check for absence, such as no wakeup or an unchanged status, reads the port or the status register in that same slot. The next stimulus comes only after that read.

// File: rtl/sport_idle_pkg.sv
// Shared types and constants for the serial port idle/wakeup controller.
// Assumes the status vector width equals the register data width.
package sport_idle_pkg;

    localparam int NSRC = 7;
    localparam int ADDR_W = 3;

    // Status / enable bit positions (software relies on these)
    localparam int B_RX_RDY  = 0;
    localparam int B_RX_EOF  = 1;
    localparam int B_RX_SERR = 2;
    localparam int B_TX_RDY  = 3;
    localparam int B_TX_EOF  = 4;
    localparam int B_TX_FS   = 5;
    localparam int B_TX_SERR = 6;

    localparam logic [ADDR_W-1:0] A_WAKE_EN = 3'd0;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_THR_RX  = 3'd2;
    localparam logic [ADDR_W-1:0] A_THR_TX  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAKING = 2'd2
    } idle_state_t;

endpackage

// File: rtl/sport_idle_events.sv
// Turns path inputs into one-cycle event pulses, one per status bit.
// Ready events fire on the rising crossing of level >= threshold+1.
// Assumes strobes are single-cycle; all events are masked while frozen.
module sport_idle_events
    import sport_idle_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic             in_idle,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_space,
    input  logic [LVL_W-1:0] thr_rx,
    input  logic [LVL_W-1:0] thr_tx,
    input  logic             rx_eof,
    input  logic             rx_sync_err,
    input  logic             tx_eof,
    input  logic             tx_fsync,
    input  logic             tx_sync_err,
    output src_vec_t         evt
);
    localparam int NRDY = 2;
    localparam logic [LVL_W:0] ONE = {{LVL_W{1'b0}}, 1'b1};

    logic [LVL_W-1:0] lvl [NRDY];
    logic [LVL_W-1:0] thr [NRDY];
    logic [NRDY-1:0]  rdy_now;
    logic [NRDY-1:0]  rdy_prev;
    logic [NRDY-1:0]  rdy_rise;

    assign lvl[0] = rx_level;
    assign lvl[1] = tx_space;
    assign thr[0] = thr_rx;
    assign thr[1] = thr_tx;

    // One comparator per buffer: level reached threshold plus one
    for (genvar g = 0; g < NRDY; g++) begin : g_rdy
        assign rdy_now[g]  = ({1'b0, lvl[g]} >= ({1'b0, thr[g]} + ONE));
        assign rdy_rise[g] = rdy_now[g] & ~rdy_prev[g];
    end

    // Remember last comparison result; held while clocks are frozen
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_prev <= '0;
        else if (!frozen) rdy_prev <= rdy_now;
    end

    // Collect raw events into status order and mask during freeze
    always_comb begin
        evt            = '0;
        evt[B_RX_RDY]  = rdy_rise[0];
        evt[B_RX_EOF]  = rx_eof;
        evt[B_RX_SERR] = rx_sync_err;
        evt[B_TX_RDY]  = rdy_rise[1];
        evt[B_TX_EOF]  = tx_eof;
        evt[B_TX_FS]   = tx_fsync & in_idle;
        evt[B_TX_SERR] = tx_sync_err;
        if (frozen) evt = '0;
    end

endmodule

// File: rtl/sport_idle_regs.sv
// Register file: wake-enable, irq-enable, two thresholds, sticky W1C status.
// Assumes LVL_W <= NSRC; read data is combinational from the address.
module sport_idle_regs
    import sport_idle_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wdata,
    input  src_vec_t          evt,
    output logic [NSRC-1:0]   rdata,
    output src_vec_t          wake_en,
    output src_vec_t          irq_en,
    output logic [LVL_W-1:0]  thr_rx,
    output logic [LVL_W-1:0]  thr_tx,
    output src_vec_t          status
);
    src_vec_t clr;

    assign clr = (we && addr == A_STATUS) ? wdata : '0;

    // Configuration registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en <= '0;
            irq_en  <= '0;
            thr_rx  <= '0;
            thr_tx  <= '0;
        end else if (we) begin
            case (addr)
                A_WAKE_EN: wake_en <= wdata;
                A_IRQ_EN:  irq_en  <= wdata;
                A_THR_RX:  thr_rx  <= wdata[LVL_W-1:0];
                A_THR_TX:  thr_tx  <= wdata[LVL_W-1:0];
                default:   ;
            endcase
        end
    end

    // Sticky status: new events win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | evt;
    end

    // Read-back multiplexer
    always_comb begin
        case (addr)
            A_WAKE_EN: rdata = wake_en;
            A_IRQ_EN:  rdata = irq_en;
            A_THR_RX:  rdata = NSRC'(thr_rx);
            A_THR_TX:  rdata = NSRC'(thr_tx);
            A_STATUS:  rdata = status;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/sport_idle_fsm.sv
// Idle handshake state machine (ACTIVE, IDLE, WAKING).
// Forced mode acknowledges at once; smart mode waits for no pending irq.
// The mode is latched when idle is entered.
module sport_idle_fsm
    import sport_idle_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idle_req,
    input  logic        smart_mode,
    input  logic        irq_pend,
    input  logic        wake_hit,
    output idle_state_t state,
    output logic        idle_ack,
    output logic        wakeup,
    output logic        clk_freeze
);
    idle_state_t state_nx;
    logic        smart_q;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: if (idle_req && (!smart_mode || !irq_pend)) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (!idle_req)                state_nx = ST_ACTIVE;
                else if (smart_q && wake_hit) state_nx = ST_WAKING;
            end
            ST_WAKING: if (!idle_req) state_nx = ST_ACTIVE;
            default: state_nx = ST_ACTIVE;
        endcase
    end

    // State register and idle-mode latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ACTIVE;
            smart_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_ACTIVE) smart_q <= smart_mode;
        end
    end

    assign idle_ack   = (state != ST_ACTIVE);
    assign wakeup     = (state == ST_WAKING);
    assign clk_freeze = (state == ST_IDLE) && !smart_q;

endmodule

// File: rtl/sport_idle_wake.sv
// Top of the serial port idle/wakeup controller: event detection,
// registers and handshake FSM. Interrupts are held off while idle.
module sport_idle_wake
    import sport_idle_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             smart_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_space,
    input  logic             rx_eof,
    input  logic             rx_sync_err,
    input  logic             tx_eof,
    input  logic             tx_fsync,
    input  logic             tx_sync_err,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [6:0]       reg_wdata,
    output logic [6:0]       reg_rdata,
    output logic             idle_ack,
    output logic             wakeup,
    output logic             clk_freeze,
    output logic             irq
);
    src_vec_t         evt, wake_en, irq_en, status_q;
    logic [LVL_W-1:0] thr_rx, thr_tx;
    idle_state_t      state;
    logic             irq_pend, wake_hit;

    assign irq_pend = |(status_q & irq_en);
    assign wake_hit = |(evt & wake_en);
    assign irq      = irq_pend && (state == ST_ACTIVE);

    sport_idle_events #(.LVL_W(LVL_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .frozen(clk_freeze), .in_idle(idle_ack),
        .rx_level(rx_level), .tx_space(tx_space), .thr_rx(thr_rx), .thr_tx(thr_tx),
        .rx_eof(rx_eof), .rx_sync_err(rx_sync_err), .tx_eof(tx_eof),
        .tx_fsync(tx_fsync), .tx_sync_err(tx_sync_err), .evt(evt)
    );

    sport_idle_regs #(.LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .evt(evt), .rdata(reg_rdata), .wake_en(wake_en), .irq_en(irq_en),
        .thr_rx(thr_rx), .thr_tx(thr_tx), .status(status_q)
    );

    sport_idle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .smart_mode(smart_mode),
        .irq_pend(irq_pend), .wake_hit(wake_hit), .state(state),
        .idle_ack(idle_ack), .wakeup(wakeup), .clk_freeze(clk_freeze)
    );

endmodule

// File: rtl/sport_idle_wake_chk.sv
// Protocol checker for sport_idle_wake, attached with bind below.
module sport_idle_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idle_req,
    input logic       smart_mode,
    input logic       idle_ack,
    input logic       wakeup,
    input logic       clk_freeze,
    input logic       irq,
    input logic       reg_we,
    input logic [6:0] status
);
    p_wake_needs_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> idle_ack);

    p_wake_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wakeup && idle_req) |=> wakeup);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && !idle_req) |=> !idle_ack);

    p_force_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && idle_req && !smart_mode) |=> (idle_ack && clk_freeze));

    p_freeze_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_freeze |-> (idle_ack && !wakeup));

    p_freeze_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_freeze && !reg_we) |=> $stable(status));

    p_irq_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> !irq);

endmodule

bind sport_idle_wake sport_idle_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .smart_mode(smart_mode),
    .idle_ack(idle_ack), .wakeup(wakeup), .clk_freeze(clk_freeze), .irq(irq),
    .reg_we(reg_we), .status(status_q)
);

// File: tb/test_sport_idle_wake.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sport_idle_wake;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, smart_mode = 0;
    logic [LVL_W-1:0] rx_level = '0, tx_space = '0;
    logic rx_eof = 0, rx_sync_err = 0, tx_eof = 0, tx_fsync = 0, tx_sync_err = 0;
    logic reg_we = 0;
    logic [2:0] reg_addr = '0;
    logic [6:0] reg_wdata = '0;
    logic [6:0] reg_rdata;
    logic idle_ack, wakeup, clk_freeze, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sport_idle_wake #(.LVL_W(LVL_W)) i_sport_idle_wake (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .smart_mode(smart_mode),
        .rx_level(rx_level), .tx_space(tx_space), .rx_eof(rx_eof),
        .rx_sync_err(rx_sync_err), .tx_eof(tx_eof), .tx_fsync(tx_fsync),
        .tx_sync_err(tx_sync_err), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_ack(idle_ack),
        .wakeup(wakeup), .clk_freeze(clk_freeze), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic t_reset();
        check("R1 idle_ack", idle_ack, 0);
        check("R1 wakeup", wakeup, 0);
        check("R1 clk_freeze", clk_freeze, 0);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 5; a++) rd_chk("R1 reg", 3'(a), 0);
    endtask

    task automatic t_regs();
        wr(3'd0, 7'h7F); wr(3'd1, 7'h55); wr(3'd2, 7'd3); wr(3'd3, 7'd5);
        rd_chk("R13 wake_en", 3'd0, 'h7F);
        rd_chk("R13 irq_en", 3'd1, 'h55);
        rd_chk("R13 thr_rx", 3'd2, 3);
        rd_chk("R13 thr_tx", 3'd3, 5);
        wr(3'd1, 7'h00);
    endtask

    task automatic t_rx_ready();
        rx_level = 3; tick();
        rd_chk("R5 below limit", 3'd4, 0);
        rx_level = 4; tick();
        rd_chk("R5 crossing", 3'd4, 'h01);
        wr(3'd4, 7'h01);
        tick();
        rd_chk("R5 held level no refire", 3'd4, 0);
        rx_level = 2; tick();
        rx_level = 4; tick();
        rd_chk("R5 second crossing", 3'd4, 'h01);
        wr(3'd4, 7'h7F);
    endtask

    task automatic t_tx_ready();
        tx_space = 5; tick();
        rd_chk("R6 below limit", 3'd4, 0);
        tx_space = 6; tick();
        rd_chk("R6 crossing", 3'd4, 'h08);
        wr(3'd4, 7'h7F);
    endtask

    task automatic t_strobes();
        rx_eof = 1; tick(); rx_eof = 0;
        rd_chk("R7 rx_eof bit1", 3'd4, 'h02);
        rx_sync_err = 1; tick(); rx_sync_err = 0;
        tx_eof = 1; tick(); tx_eof = 0;
        tx_sync_err = 1; tick(); tx_sync_err = 0;
        rd_chk("R7 all strobes", 3'd4, 'h56);
        tx_fsync = 1; tick(); tx_fsync = 0;
        rd_chk("R8 fsync ignored when active", 3'd4, 'h56);
        wr(3'd4, 7'h7F);
    endtask

    task automatic t_w1c();
        rx_eof = 1; tick(); rx_eof = 0;
        wr(3'd4, 7'h00);
        rd_chk("R12 write zero keeps", 3'd4, 'h02);
        rx_eof = 1;
        wr(3'd4, 7'h02);
        rx_eof = 0;
        rd_chk("R12 set beats clear", 3'd4, 'h02);
        wr(3'd4, 7'h02);
        rd_chk("R12 clear", 3'd4, 0);
    endtask

    task automatic t_irq();
        wr(3'd1, 7'h02);
        check("R11 no status no irq", irq, 0);
        rx_eof = 1; tick(); rx_eof = 0;
        check("R11 irq on enabled bit", irq, 1);
        wr(3'd1, 7'h00);
        check("R11 masked", irq, 0);
        wr(3'd4, 7'h7F);
    endtask

    task automatic t_force();
        smart_mode = 0;
        wr(3'd1, 7'h02);
        rx_eof = 1; tick(); rx_eof = 0;
        idle_req = 1; tick();
        check("R2 immediate ack", idle_ack, 1);
        check("R2 freeze", clk_freeze, 1);
        check("R11 deferred in idle", irq, 0);
        rx_sync_err = 1; tx_eof = 1; tick(); rx_sync_err = 0; tx_eof = 0;
        rd_chk("R3 status frozen", 3'd4, 'h02);
        check("R3 no wakeup", wakeup, 0);
        idle_req = 0; tick();
        check("R9 release ack", idle_ack, 0);
        check("R2 freeze off", clk_freeze, 0);
        check("R11 irq after exit", irq, 1);
        wr(3'd4, 7'h7F);
    endtask

    task automatic t_smart_block();
        smart_mode = 1;
        rx_eof = 1; tick(); rx_eof = 0;
        idle_req = 1; tick();
        check("R4 blocked by pending irq", idle_ack, 0);
        wr(3'd4, 7'h7F);
        check("R4 still active on clear cycle", idle_ack, 0);
        tick();
        check("R4 ack after clear", idle_ack, 1);
        check("R4 no freeze in smart", clk_freeze, 0);
    endtask

    task automatic t_smart_wake();
        wr(3'd0, 7'h20);
        rx_eof = 1; tick(); rx_eof = 0;
        check("R10 no wakeup unenabled", wakeup, 0);
        rd_chk("R10 status set", 3'd4, 'h02);
        check("R11 deferred", irq, 0);
        tx_fsync = 1; tick(); tx_fsync = 0;
        check("R9 wakeup", wakeup, 1);
        rd_chk("R8 fsync in idle", 3'd4, 'h22);
        tick(); tick();
        check("R9 wakeup holds", wakeup, 1);
        idle_req = 0; tick();
        check("R9 wakeup drops", wakeup, 0);
        check("R9 ack drops", idle_ack, 0);
        check("R11 irq after wake", irq, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        t_reset();
        t_regs();
        t_rx_ready();
        t_tx_ready();
        t_strobes();
        t_w1c();
        t_irq();
        t_force();
        t_smart_block();
        t_smart_wake();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule